// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block keeps one private, direct-mapped, write-back cache coherent with its peers on a shared bus. Each line holds one word and carries a three-valued tag state: invalid, shared (clean, possibly also held by others) or exclusive (dirty and held only here). The block serves requests from its own processor. When a request cannot be completed locally it asks for the bus, holds the processor off with a busy flag, and completes when the bus is granted.

At the same time it watches every transaction that other caches place on the bus. A peer's write miss to a line held here invalidates that line. A peer's read miss to a line held here as exclusive makes this cache provide the word and tell memory to stay silent, and the line drops to shared.

Only one bus transaction is in flight at a time. Arbitration and memory sit outside the block. Snoops are serviced in every cycle, including while the processor side is waiting for the bus.

Top module: `snoop_coh_ctrl`

## Requirements
- R1: After the synchronous active-high reset every line is invalid (state code 0; shared is 1, exclusive is 2), and `cpu_busy`, `bus_req`, `cpu_done` and `snoop_abort` are low, so the first read of any address causes a bus read miss.
- R2: A processor read whose line is invalid or holds another tag issues a bus read miss (op code 1) for the requested address. When granted, it fills the line from `bus_rdata`, marks it shared, and returns that word on `cpu_rdata` with `cpu_done` high in the cycle after the grant edge.
- R3: A processor read that hits a shared or exclusive line makes no bus request, leaves the state unchanged, and returns the stored word with `cpu_done` high in the cycle after the accepting edge.
- R4: A processor write to a line that is shared, invalid or mismatched issues a bus write miss (op code 2) for its address, even on a shared hit. When granted, the line holds the new word and becomes exclusive.
- R5: Processor reads and writes that hit an exclusive line make no bus request and leave the line exclusive, with a write updating the stored word.
- R6: If the line to be replaced is exclusive with a different tag, a write-back (op code 3) carrying the victim's address and word is issued and granted before the miss for the new address.
- R7: A snooped write miss (`snoop_op` 2) whose address matches a valid line here invalidates it, without asserting `snoop_abort`.
- R8: A snooped read miss (`snoop_op` 1) matching an exclusive line raises `snoop_abort` with the line's word on `snoop_data` in the next cycle, and leaves the line shared.
- R9: A snooped read miss to a shared or absent line, and any other snoop code, has no effect on `snoop_abort` or on line state.
- R10: While a request waits for the bus, `cpu_busy` and `bus_req` stay high until `bus_grant` is seen, and `cpu_done` stays low.
- R11: Snoops arriving while the processor is stalled are serviced at once. A stalled write-back whose victim a snoop has cleaned or invalidated is dropped in favour of the miss.
- R12: When `snoop_valid` and a new processor request arrive in the same cycle, the snoop is handled first and the request is taken on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_done` |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_busy | output | 1 | Request is waiting on the bus |
| bus_grant | input | 1 | Bus granted to the current request |
| bus_req | output | 1 | Bus request |
| bus_op | output | 2 | 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Address of the requested transaction |
| bus_wdata | output | DATA_W | Word carried by a write-back |
| bus_rdata | input | DATA_W | Fill word, valid with `bus_grant` on a read miss |
| snoop_valid | input | 1 | A peer transaction is on the bus |
| snoop_op | input | 2 | Peer transaction code, same encoding as `bus_op` |
| snoop_addr | input | ADDR_W | Peer transaction address |
| snoop_abort | output | 1 | This cache supplies the word, so memory must not respond |
| snoop_data | output | DATA_W | Supplied word, valid with `snoop_abort` |

## Verification
The bench builds the block with its default parameters: 16 lines, 32-bit addresses and 32-bit data. It confines all processor and snoop addresses to 64 words, so four tags compete for every line. That makes dirty evictions, write-upgrades of shared lines and snoop hits on exclusive lines frequent under random stimulus. With the default geometry, a snoop injected into a stalled write-back reaches the case where the victim is cleaned before the bus grant.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_RDMISS = 2'd1,
    OP_WRMISS = 2'd2,
    OP_WBACK  = 2'd3
  } bus_op_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_WBACK = 2'd1,
    CS_MISS  = 2'd2
  } cpu_fsm_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] cpu_idx,
  output line_st_e         cpu_st,
  output logic [TAG_W-1:0] cpu_tag,
  input  logic             cpu_wr,
  input  line_st_e         cpu_nst,
  input  logic [TAG_W-1:0] cpu_ntag,
  input  logic [IDX_W-1:0] snp_idx,
  output line_st_e         snp_st,
  output logic [TAG_W-1:0] snp_tag,
  input  logic             snp_wr,
  input  line_st_e         snp_nst
);
  line_st_e         st [LINES];
  logic [TAG_W-1:0] tg [LINES];

  assign cpu_st  = st[cpu_idx];
  assign cpu_tag = tg[cpu_idx];
  assign snp_st  = st[snp_idx];
  assign snp_tag = tg[snp_idx];

  // state bits: snoop update written last so it wins on a shared index
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st[i] <= LN_INV;
    end else begin
      if (cpu_wr) st[cpu_idx] <= cpu_nst;
      if (snp_wr) st[snp_idx] <= snp_nst;
    end
  end

  // tags need no reset, so they can sit in distributed RAM
  always_ff @(posedge clk) begin
    if (cpu_wr) tg[cpu_idx] <= cpu_ntag;
  end
endmodule

// File: rtl/coh_data_ram.sv
module coh_data_ram #(
  parameter int LINES  = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (wr) mem[widx] <= wdata;
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
  import coh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic [IDX_W-1:0]  snp_idx,
  input  line_st_e          line_st,
  input  logic [TAG_W-1:0]  line_tag,
  input  logic [DATA_W-1:0] line_data,
  output logic              st_wr,
  output line_st_e          st_next,
  output logic              abort_q,
  output logic [DATA_W-1:0] data_q
);
  logic hit, is_rd, is_wr, supply;

  assign snp_idx = snoop_addr[IDX_W-1:0];
  assign hit     = (line_st != LN_INV) && (line_tag == snoop_addr[ADDR_W-1:IDX_W]);
  assign is_rd   = snoop_valid && (snoop_op == OP_RDMISS);
  assign is_wr   = snoop_valid && (snoop_op == OP_WRMISS);
  assign supply  = is_rd && hit && (line_st == LN_EXC);
  assign st_wr   = supply || (is_wr && hit);
  assign st_next = is_wr ? LN_INV : LN_SHR;

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_q <= 1'b0;
      data_q  <= '0;
    end else begin
      abort_q <= supply;
      if (supply) data_q <= line_data;
    end
  end

  // R8
  abort_src_chk: assert property (@(posedge clk) disable iff (rst)
    abort_q |-> ($past(snoop_valid) && $past(snoop_op) == OP_RDMISS));

  // R9
  no_abort_other_chk: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && snoop_op != OP_RDMISS) |=> !abort_q);
endmodule

// File: rtl/snoop_coh_ctrl.sv
module snoop_coh_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_done,
  output logic              cpu_busy,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_abort,
  output logic [DATA_W-1:0] snoop_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  cpu_fsm_e          fsm;
  bus_op_e           op_q;
  logic              req_we;
  logic [ADDR_W-1:0] req_addr, baddr_q, lk_addr;
  logic [DATA_W-1:0] req_wdata, bwd_q, rdata_q, c_data, s_data, ram_wd;
  logic              done_q, accept, tag_hit, victim_dirty, local_ok;
  logic [IDX_W-1:0]  lk_idx, s_idx;
  logic [TAG_W-1:0]  lk_tag, c_tg, s_tg, ntag;
  line_st_e          c_st, s_st, nst, s_nst;
  logic              st_wr, s_wr, ram_wr;

  assign lk_addr      = (fsm == CS_IDLE) ? cpu_addr : req_addr;
  assign lk_idx       = lk_addr[IDX_W-1:0];
  assign lk_tag       = lk_addr[ADDR_W-1:IDX_W];
  assign tag_hit      = (c_st != LN_INV) && (c_tg == lk_tag);
  assign victim_dirty = (c_st == LN_EXC) && (c_tg != lk_tag);
  assign accept       = (fsm == CS_IDLE) && cpu_req && !snoop_valid;
  assign local_ok     = tag_hit && (!cpu_we || c_st == LN_EXC);

  coh_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
    .clk(clk), .rst(rst),
    .cpu_idx(lk_idx), .cpu_st(c_st), .cpu_tag(c_tg),
    .cpu_wr(st_wr), .cpu_nst(nst), .cpu_ntag(ntag),
    .snp_idx(s_idx), .snp_st(s_st), .snp_tag(s_tg),
    .snp_wr(s_wr), .snp_nst(s_nst)
  );

  coh_data_ram #(.LINES(LINES), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .wr(ram_wr), .widx(lk_idx), .wdata(ram_wd),
    .ridx_a(lk_idx), .rdata_a(c_data), .ridx_b(s_idx), .rdata_b(s_data)
  );

  coh_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snoop_valid(snoop_valid), .snoop_op(snoop_op), .snoop_addr(snoop_addr),
    .snp_idx(s_idx), .line_st(s_st), .line_tag(s_tg), .line_data(s_data),
    .st_wr(s_wr), .st_next(s_nst), .abort_q(snoop_abort), .data_q(snoop_data)
  );

  // line and word updates from the processor side
  always_comb begin
    st_wr  = 1'b0;
    nst    = LN_SHR;
    ntag   = lk_tag;
    ram_wr = 1'b0;
    ram_wd = cpu_wdata;
    if (accept && cpu_we && tag_hit && c_st == LN_EXC) begin
      ram_wr = 1'b1;
    end else if (fsm == CS_WBACK && bus_grant && victim_dirty) begin
      st_wr = 1'b1;
      ntag  = c_tg;
    end else if (fsm == CS_MISS && bus_grant) begin
      st_wr  = 1'b1;
      nst    = req_we ? LN_EXC : LN_SHR;
      ram_wr = 1'b1;
      ram_wd = req_we ? req_wdata : bus_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsm       <= CS_IDLE;
      op_q      <= OP_NONE;
      done_q    <= 1'b0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      baddr_q   <= '0;
      bwd_q     <= '0;
      rdata_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (fsm)
        CS_IDLE: if (accept) begin
          req_we    <= cpu_we;
          req_addr  <= cpu_addr;
          req_wdata <= cpu_wdata;
          if (local_ok) begin
            done_q <= 1'b1;
            if (!cpu_we) rdata_q <= c_data;
          end else if (victim_dirty) begin
            fsm     <= CS_WBACK;
            op_q    <= OP_WBACK;
            baddr_q <= {c_tg, lk_idx};
            bwd_q   <= c_data;
          end else begin
            fsm     <= CS_MISS;
            op_q    <= cpu_we ? OP_WRMISS : OP_RDMISS;
            baddr_q <= cpu_addr;
            bwd_q   <= cpu_wdata;
          end
        end
        CS_WBACK: if (bus_grant || !victim_dirty) begin
          fsm     <= CS_MISS;
          op_q    <= req_we ? OP_WRMISS : OP_RDMISS;
          baddr_q <= req_addr;
          bwd_q   <= req_wdata;
        end
        CS_MISS: if (bus_grant) begin
          fsm    <= CS_IDLE;
          op_q   <= OP_NONE;
          done_q <= 1'b1;
          if (!req_we) rdata_q <= bus_rdata;
        end
        default: fsm <= CS_IDLE;
      endcase
    end
  end

  assign cpu_busy  = (fsm != CS_IDLE);
  assign bus_req   = (fsm != CS_IDLE);
  assign bus_op    = op_q;
  assign bus_addr  = baddr_q;
  assign bus_wdata = bwd_q;
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_busy && !bus_grant) |=> cpu_busy);

  // R12
  snoop_first_chk: assert property (@(posedge clk) disable iff (rst)
    (fsm == CS_IDLE && snoop_valid) |=> (fsm == CS_IDLE && !cpu_done));

  // R6
  wb_order_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_op == OP_WBACK && bus_grant) |=> (bus_req && bus_op != OP_WBACK));

  // R2
  fill_done_chk: assert property (@(posedge clk) disable iff (rst)
    (fsm == CS_MISS && bus_grant) |=> cpu_done);
endmodule

// File: tb/snoop_coh_ctrl_test.sv
`timescale 1ns/1ps
module snoop_coh_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 0, cpu_we = 0, bus_grant = 0, snoop_valid = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, bus_rdata = 0, snoop_addr = 0;
  logic [1:0]  snoop_op = 0;
  logic [31:0] cpu_rdata, bus_addr, bus_wdata, snoop_data;
  logic [1:0]  bus_op;
  logic        cpu_done, cpu_busy, bus_req, snoop_abort;

  always #2.5 clk = ~clk;

  snoop_coh_ctrl uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done), .cpu_busy(cpu_busy),
    .bus_grant(bus_grant), .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .snoop_valid(snoop_valid),
    .snoop_op(snoop_op), .snoop_addr(snoop_addr), .snoop_abort(snoop_abort),
    .snoop_data(snoop_data)
  );

  int checks = 0, fails = 0, cycles = 0;
  int          ms [16];
  logic [27:0] mt [16];
  logic [31:0] md [16];
  logic [31:0] mem [64];

  function automatic logic [31:0] mem_seed(int i);
    return 32'hA500_0000 + i * 7;
  endfunction

  function automatic string seq_label(bit wb, bit miss, bit we);
    if (wb) return "R6";
    if (!miss) return we ? "R5" : "R3";
    return we ? "R4" : "R2";
  endfunction

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  task automatic snoop_model(logic [1:0] op, logic [31:0] sa, output bit ab, output logic [31:0] dt);
    int i = sa[3:0];
    bit hit = ms[i] != 0 && mt[i] == sa[31:4];
    ab = 0; dt = 0;
    if (op == 2 && hit) ms[i] = 0;
    if (op == 1 && hit && ms[i] == 2) begin
      ab = 1; dt = md[i]; ms[i] = 1; mem[sa[5:0]] = md[i];
    end
  endtask

  task automatic check_snoop(bit ab, logic [31:0] dt, string rq);
    check(snoop_abort == ab, rq, {31'd0, snoop_abort}, {31'd0, ab});
    if (ab) check(snoop_data == dt, rq, snoop_data, dt);
  endtask

  task automatic do_snoop(logic [1:0] op, logic [31:0] sa);
    bit ab; logic [31:0] dt;
    @(negedge clk);
    snoop_valid = 1; snoop_op = op; snoop_addr = sa;
    snoop_model(op, sa, ab, dt);
    @(negedge clk);
    snoop_valid = 0;
    check_snoop(ab, dt, op == 2 ? "R7" : (ab ? "R8" : "R9"));
  endtask

  // mode 0 plain, 1 snoop in the request cycle, 2 snoop while stalled
  task automatic cpu_op(bit we, logic [31:0] a, logic [31:0] wd, int mode,
                        logic [1:0] sop, logic [31:0] sa);
    int i = a[3:0];
    bit hit, ewb, emiss, ab, injected = 0;
    logic [31:0] dt, exp_rd;
    logic [1:0] g [2];
    int ng = 0, cyc = 0;
    @(negedge clk);
    if (mode == 1) begin
      snoop_valid = 1; snoop_op = sop; snoop_addr = sa;
      snoop_model(sop, sa, ab, dt);
    end
    hit   = ms[i] != 0 && mt[i] == a[31:4];
    emiss = !(hit && (!we || ms[i] == 2));
    ewb   = emiss && ms[i] == 2 && !hit;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    if (mode == 1) begin
      @(negedge clk);
      snoop_valid = 0;
      check_snoop(ab, dt, "R12");
      check(!cpu_done && !cpu_busy, "R12", {30'd0, cpu_done, cpu_busy}, 32'd0);
    end
    while (1) begin
      @(negedge clk);
      bus_grant = 0;
      cyc++;
      if (cyc > 200) begin
        check(0, "R10", 32'd0, 32'd1);
        break;
      end
      if (cpu_done) break;
      if (bus_req) begin
        if (mode == 2 && !injected) begin
          injected = 1;
          snoop_valid = 1; snoop_op = sop; snoop_addr = sa;
          snoop_model(sop, sa, ab, dt);
          @(negedge clk);
          snoop_valid = 0;
          check_snoop(ab, dt, "R11");
          check(cpu_busy && bus_req && !cpu_done, "R10", {31'd0, cpu_busy}, 32'd1);
          @(negedge clk);
          ewb = ewb && ms[i] == 2;
        end
        check(cpu_busy && !cpu_done, "R10", {31'd0, cpu_busy}, 32'd1);
        if (bus_op == 2'd3) begin
          check(bus_addr == {mt[i], i[3:0]}, "R6", bus_addr, {mt[i], i[3:0]});
          check(bus_wdata == md[i], "R6", bus_wdata, md[i]);
          mem[bus_addr[5:0]] = md[i];
        end else begin
          check(bus_addr == a, seq_label(0, 1, we), bus_addr, a);
        end
        bus_rdata = mem[bus_addr[5:0]];
        if (ng < 2) g[ng] = bus_op;
        ng++;
        bus_grant = 1;
      end
    end
    cpu_req = 0;
    if (ewb)
      check(ng == 2 && g[0] == 2'd3 && g[1] == (we ? 2'd2 : 2'd1), "R6", ng, 2);
    else if (emiss)
      check(ng == 1 && g[0] == (we ? 2'd2 : 2'd1), seq_label(0, 1, we), ng, 1);
    else
      check(ng == 0 && cyc == 1, seq_label(0, 0, we), ng, 0);
    if (!we) begin
      exp_rd = emiss ? mem[a[5:0]] : md[i];
      check(cpu_rdata == exp_rd, seq_label(0, emiss, 0), cpu_rdata, exp_rd);
    end
    if (emiss) begin
      ms[i] = we ? 2 : 1; mt[i] = a[31:4]; md[i] = we ? wd : mem[a[5:0]];
    end else if (we) begin
      md[i] = wd;
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int k = 0; k < 16; k++) begin ms[k] = 0; mt[k] = 0; md[k] = 0; end
    for (int k = 0; k < 64; k++) mem[k] = mem_seed(k);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(!cpu_busy && !bus_req && !cpu_done && !snoop_abort, "R1",
          {28'd0, cpu_busy, bus_req, cpu_done, snoop_abort}, 32'd0);
    cpu_op(0, 32'd5, 0, 0, 0, 0);                // R1/R2 miss after reset
    cpu_op(0, 32'd5, 0, 0, 0, 0);                // R3 read hit
    cpu_op(1, 32'd5, 32'h1111_0001, 0, 0, 0);    // R4 upgrade of shared line
    cpu_op(1, 32'd5, 32'h1111_0002, 0, 0, 0);    // R5 write hit exclusive
    cpu_op(0, 32'd5, 0, 0, 0, 0);                // R5 read hit exclusive
    cpu_op(0, 32'd21, 0, 0, 0, 0);               // R6 dirty victim
    cpu_op(1, 32'd7, 32'h2222_0007, 0, 0, 0);
    do_snoop(2'd1, 32'd7);                       // R8 supply and abort
    cpu_op(1, 32'd7, 32'h2222_0008, 0, 0, 0);    // R8 line now shared
    do_snoop(2'd2, 32'd7);                       // R7 invalidate
    cpu_op(0, 32'd7, 0, 0, 0, 0);                // R7 read misses again
    do_snoop(2'd1, 32'd21);                      // R9 shared, no abort
    do_snoop(2'd3, 32'd21);                      // R9 other code ignored
    cpu_op(1, 32'd9, 32'h3333_0009, 0, 0, 0);
    cpu_op(0, 32'd25, 0, 2, 2'd1, 32'd9);        // R11 victim cleaned while stalled
    cpu_op(1, 32'd25, 32'h4444_0025, 1, 2'd2, 32'd25); // R12 same-cycle snoop
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 9);
      logic [31:0] a = $urandom_range(0, 63);
      logic [31:0] s = $urandom_range(0, 63);
      logic [1:0] op = 2'($urandom_range(1, 3));
      if (kind < 4) do_snoop(op, s);
      else cpu_op(kind[0], a, $urandom, kind == 4 ? 1 : (kind < 7 ? 2 : 0), op, s);
    end
    repeat (3) @(negedge clk);
    summary();
  end
endmodule